// File: doc/BRIEF.md
# Dual-Port Mailbox Memory with Polled Flag Handshake

This block is a shared byte memory with two fully independent synchronous ports. One port belongs to a host processor. The other belongs to the controller that drives a CAN network. Messages cross between the two sides through two fixed buffer windows, one per direction. Each direction also has a single flag byte that software on both sides uses as a handshake.

A producer first writes a complete message into its buffer. It then writes the ready value 0xA5 into the flag byte for that direction. The consumer polls that flag byte through its own port. Once it reads 0xA5, it reads the buffer and then writes 0x00 back to the flag. The producer learns that the buffer is free again by polling for 0x00. The memory gives the flag bytes no special meaning: it stores and returns them like any other byte, and the protocol lives entirely in software. The memory itself only guarantees the following:
- the ordering and latency of reads and writes,
- a known cleared state of the flags after reset,
- a fixed winner when both ports write the same byte in the same cycle.

Each port has the plain signals address, write data, write enable and read data. The ports have no handshake and no back-pressure: every port accepts one access per clock.

Top module: `mbx_dual_port`

## Requirements
- R1: After reset, both flag bytes (receive flag at address 0x000, transmit flag at address 0x001) read 0x00 from either port until one of the ports writes them.
- R2: A read returns the byte at the address presented at a rising edge on that port's read data, one clock after that edge.
- R3: A byte written by either port at any address from 0x000 to 0x3FF is returned by later reads of that address from both ports.
- R4: When a port reads an address that the same port or the other port writes at the same edge, the read returns the byte stored before that write.
- R5: When both ports write the same address at the same edge, the controller port's data is stored and `collision` is high for exactly the one clock that follows that edge.
- R6: When the ports write different addresses at the same edge, both bytes are stored and `collision` stays low. `collision` is low after any edge without a same-address double write.
- R7: Each flag byte holds the value last written to it. A flag that a producer sets to 0xA5 reads back as 0xA5 at the consumer's port, and it reads 0x00 after the consumer writes 0x00.
- R8: The transmit buffer covers 0x010 to 0x08F and the receive buffer covers 0x090 to 0x10F, 128 bytes each. A whole message written into one buffer before its flag is set reads back intact at the other port, and it is not disturbed by traffic in the opposite direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset; clears the flag bytes and the read data |
| host_addr | input | 10 | Host port byte address |
| host_wdata | input | 8 | Host port write data |
| host_we | input | 1 | Host port write enable |
| host_rdata | output | 8 | Host port read data, one clock after the address |
| ctl_addr | input | 10 | Controller port byte address |
| ctl_wdata | input | 8 | Controller port write data |
| ctl_we | input | 1 | Controller port write enable; wins a same-address clash |
| ctl_rdata | output | 8 | Controller port read data, one clock after the address |
| collision | output | 1 | One-clock pulse after both ports wrote the same address |

## Verification
The assertions check, on every cycle, that `collision` pulses exactly after same-address double writes and at no other time. They also check that every read of either flag byte, from either port, returns the value that a flag-only model of the write priority predicts, including the old value during a same-edge write and the cleared value right after reset. Only the bench's scenarios can show the handshake as a whole. In those scenarios every byte of both 128-byte buffers is filled, the consumer polls and never sees 0xA5 before the last data byte has been written, the buffer reads back intact, and the flag returns to 0x00. Read-before-write ordering on buffer bytes, and the contents stored after a collision, are likewise shown only by directed bench traffic.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_AW = 10;
  localparam int unsigned MBX_DW = 8;
  localparam int unsigned MBX_NFLAGS = 2;
  localparam int unsigned MBX_BUF_LEN = 128;

  // flag index 0 = receive direction (controller to host), index 1 = transmit
  localparam logic [MBX_AW-1:0] MBX_FLAG_BASE = 10'h000;
  localparam logic [MBX_AW-1:0] MBX_RX_FLAG   = 10'h000;
  localparam logic [MBX_AW-1:0] MBX_TX_FLAG   = 10'h001;
  localparam logic [MBX_AW-1:0] MBX_TX_BUF    = 10'h010;
  localparam logic [MBX_AW-1:0] MBX_RX_BUF    = 10'h090;

  localparam logic [MBX_DW-1:0] MBX_FLAG_SET = 8'hA5;
  localparam logic [MBX_DW-1:0] MBX_FLAG_CLR = 8'h00;
endpackage

// File: rtl/mbx_wr_arbiter.sv
module mbx_wr_arbiter #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic          ctl_we,
  input  logic [AW-1:0] ctl_addr,
  output logic          host_commit,
  output logic          ctl_commit,
  output logic          clash_q
);
  logic clash;

  // the controller side always keeps its write; the host yields on a clash
  always_comb begin
    clash       = host_we && ctl_we && (host_addr == ctl_addr);
    host_commit = host_we && !clash;
    ctl_commit  = ctl_we;
  end

  always_ff @(posedge clk) begin
    if (rst) clash_q <= 1'b0;
    else     clash_q <= clash;
  end
endmodule

// File: rtl/mbx_flag_bank.sv
module mbx_flag_bank #(
  parameter int unsigned   AW   = 10,
  parameter int unsigned   DW   = 8,
  parameter int unsigned   NF   = 2,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [DW-1:0] CLR  = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_commit,
  input  logic [AW-1:0]          host_addr,
  input  logic [DW-1:0]          host_wdata,
  input  logic                   ctl_commit,
  input  logic [AW-1:0]          ctl_addr,
  input  logic [DW-1:0]          ctl_wdata,
  output logic [NF-1:0][DW-1:0]  flag_q
);
  genvar gi;
  generate
    for (gi = 0; gi < NF; gi++) begin : g_flag
      localparam logic [AW-1:0] FADDR = BASE + AW'(gi);
      always_ff @(posedge clk) begin
        if (rst)
          flag_q[gi] <= CLR;
        else if (ctl_commit && ctl_addr == FADDR)
          flag_q[gi] <= ctl_wdata;
        else if (host_commit && host_addr == FADDR)
          flag_q[gi] <= host_wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/mbx_ram.sv
module mbx_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8,
  parameter int unsigned NP = 2
) (
  input  logic                  clk,
  input  logic                  host_commit,
  input  logic [AW-1:0]         host_addr,
  input  logic [DW-1:0]         host_wdata,
  input  logic                  ctl_commit,
  input  logic [AW-1:0]         ctl_addr,
  input  logic [DW-1:0]         ctl_wdata,
  input  logic [NP-1:0][AW-1:0] rd_addr,
  output logic [NP-1:0][DW-1:0] rd_q
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // arbiter never commits both to one address, so order here is only a backstop
  always_ff @(posedge clk) begin
    if (host_commit) mem[host_addr] <= host_wdata;
    if (ctl_commit)  mem[ctl_addr]  <= ctl_wdata;
  end

  genvar gp;
  generate
    for (gp = 0; gp < NP; gp++) begin : g_rd
      always_ff @(posedge clk) rd_q[gp] <= mem[rd_addr[gp]];
    end
  endgenerate
endmodule

// File: rtl/mbx_read_mux.sv
module mbx_read_mux #(
  parameter int unsigned   AW   = 10,
  parameter int unsigned   DW   = 8,
  parameter int unsigned   NF   = 2,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [DW-1:0] CLR  = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AW-1:0]         addr,
  input  logic [NF-1:0][DW-1:0] flags,
  input  logic [DW-1:0]         ram_q,
  output logic [DW-1:0]         rdata
);
  logic          hit;
  logic [DW-1:0] fval;
  logic          hit_q;
  logic [DW-1:0] fval_q;

  always_comb begin
    hit  = 1'b0;
    fval = CLR;
    for (int i = 0; i < NF; i++) begin
      if (addr == BASE + AW'(i)) begin
        hit  = 1'b1;
        fval = flags[i];
      end
    end
  end

  // capture the pre-edge flag value so flag reads share the RAM's read-first order
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b1;
      fval_q <= CLR;
    end else begin
      hit_q  <= hit;
      fval_q <= fval;
    end
  end

  assign rdata = hit_q ? fval_q : ram_q;
endmodule

// File: rtl/mbx_dual_port.sv
module mbx_dual_port
  import mbx_pkg::*;
#(
  parameter int unsigned AW = MBX_AW,
  parameter int unsigned DW = MBX_DW,
  parameter int unsigned NF = MBX_NFLAGS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_we,
  output logic [DW-1:0] host_rdata,
  input  logic [AW-1:0] ctl_addr,
  input  logic [DW-1:0] ctl_wdata,
  input  logic          ctl_we,
  output logic [DW-1:0] ctl_rdata,
  output logic          collision
);
  localparam int unsigned NP = 2;
  localparam logic [AW-1:0] FBASE = AW'(MBX_FLAG_BASE);
  localparam logic [DW-1:0] FCLR  = DW'(MBX_FLAG_CLR);

  logic                  host_commit;
  logic                  ctl_commit;
  logic [NF-1:0][DW-1:0] flag_q;
  logic [NP-1:0][AW-1:0] rd_addr;
  logic [NP-1:0][DW-1:0] rd_q;
  logic [NP-1:0][DW-1:0] port_rdata;

  mbx_wr_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_addr(host_addr),
    .ctl_we(ctl_we), .ctl_addr(ctl_addr),
    .host_commit(host_commit), .ctl_commit(ctl_commit),
    .clash_q(collision)
  );

  mbx_flag_bank #(.AW(AW), .DW(DW), .NF(NF), .BASE(FBASE), .CLR(FCLR)) u_flags (
    .clk(clk), .rst(rst),
    .host_commit(host_commit), .host_addr(host_addr), .host_wdata(host_wdata),
    .ctl_commit(ctl_commit), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .flag_q(flag_q)
  );

  assign rd_addr[0] = host_addr;
  assign rd_addr[1] = ctl_addr;

  mbx_ram #(.AW(AW), .DW(DW), .NP(NP)) u_ram (
    .clk(clk),
    .host_commit(host_commit), .host_addr(host_addr), .host_wdata(host_wdata),
    .ctl_commit(ctl_commit), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .rd_addr(rd_addr), .rd_q(rd_q)
  );

  genvar gp;
  generate
    for (gp = 0; gp < NP; gp++) begin : g_port
      mbx_read_mux #(.AW(AW), .DW(DW), .NF(NF), .BASE(FBASE), .CLR(FCLR)) u_mux (
        .clk(clk), .rst(rst),
        .addr(rd_addr[gp]), .flags(flag_q), .ram_q(rd_q[gp]),
        .rdata(port_rdata[gp])
      );
    end
  endgenerate

  assign host_rdata = port_rdata[0];
  assign ctl_rdata  = port_rdata[1];
endmodule

// File: rtl/mbx_dual_port_chk.sv
module mbx_dual_port_chk
  import mbx_pkg::*;
#(
  parameter int unsigned AW = MBX_AW,
  parameter int unsigned DW = MBX_DW
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] host_addr,
  input logic [DW-1:0] host_wdata,
  input logic          host_we,
  input logic [DW-1:0] host_rdata,
  input logic [AW-1:0] ctl_addr,
  input logic [DW-1:0] ctl_wdata,
  input logic          ctl_we,
  input logic [DW-1:0] ctl_rdata,
  input logic          collision
);
  logic [DW-1:0] sh_rx, sh_tx;
  logic          rst_d;
  logic          same_wr;

  assign same_wr = host_we && ctl_we && (host_addr == ctl_addr);

  // flag-only model of write priority: controller side first
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      sh_rx <= DW'(MBX_FLAG_CLR);
      sh_tx <= DW'(MBX_FLAG_CLR);
    end else begin
      if (ctl_we && ctl_addr == AW'(MBX_RX_FLAG))        sh_rx <= ctl_wdata;
      else if (host_we && host_addr == AW'(MBX_RX_FLAG)) sh_rx <= host_wdata;
      if (ctl_we && ctl_addr == AW'(MBX_TX_FLAG))        sh_tx <= ctl_wdata;
      else if (host_we && host_addr == AW'(MBX_TX_FLAG)) sh_tx <= host_wdata;
    end
  end

  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      assert_reset_clear_R1: assert (host_rdata == '0 && ctl_rdata == '0);
    end
  end

  assert_clash_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    same_wr |=> collision);

  assert_clash_cause_R6: assert property (@(posedge clk) disable iff (rst)
    collision |-> $past(same_wr));

  assert_host_rxflag_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(host_addr) == AW'(MBX_RX_FLAG)) |-> host_rdata == $past(sh_rx));

  assert_host_txflag_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(host_addr) == AW'(MBX_TX_FLAG)) |-> host_rdata == $past(sh_tx));

  assert_ctl_rxflag_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl_addr) == AW'(MBX_RX_FLAG)) |-> ctl_rdata == $past(sh_rx));

  assert_ctl_txflag_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl_addr) == AW'(MBX_TX_FLAG)) |-> ctl_rdata == $past(sh_tx));
endmodule

bind mbx_dual_port mbx_dual_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we), .host_rdata(host_rdata),
  .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_we(ctl_we), .ctl_rdata(ctl_rdata),
  .collision(collision)
);

// File: tb/mbx_dual_port_tb.sv
module mbx_dual_port_tb;
  localparam logic [9:0] RXF = 10'h000;
  localparam logic [9:0] TXF = 10'h001;
  localparam logic [9:0] TXB = 10'h010;
  localparam logic [9:0] RXB = 10'h090;
  localparam int BLEN = 128;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] host_addr = '0, ctl_addr = '0;
  logic [7:0] host_wdata = '0, ctl_wdata = '0;
  logic       host_we = 1'b0, ctl_we = 1'b0;
  logic [7:0] host_rdata, ctl_rdata;
  logic       collision;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] hq, cq;
  logic       colq;

  always #2 clk = ~clk;

  mbx_dual_port u_dut (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we), .host_rdata(host_rdata),
    .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_we(ctl_we), .ctl_rdata(ctl_rdata),
    .collision(collision)
  );

  function automatic logic [7:0] pat(input int dir, input int idx, input int round);
    return 8'((idx * 37 + dir * 91 + round * 13 + 5) & 255);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // drive at a falling edge, pass one rising edge, sample at the next falling edge
  task automatic cyc(input logic hw, input logic [9:0] ha, input logic [7:0] hd,
                     input logic cw, input logic [9:0] ca, input logic [7:0] cd);
    host_we = hw; host_addr = ha; host_wdata = hd;
    ctl_we = cw;  ctl_addr = ca;  ctl_wdata = cd;
    @(negedge clk);
    hq = host_rdata; cq = ctl_rdata; colq = collision;
  endtask

  task automatic host_to_ctl(input int round);
    for (int i = 0; i < BLEN; i++) begin
      cyc(1, TXB + 10'(i), pat(0, i, round), 0, TXF, 8'h00);
      chk("R7 tx flag set before data complete", cq, 8'h00);
    end
    cyc(1, TXF, 8'hA5, 0, TXF, 8'h00);
    chk("R4 tx flag read during set", cq, 8'h00);
    cyc(0, TXF, 8'h00, 0, TXF, 8'h00);
    chk("R7 tx flag seen by controller", cq, 8'hA5);
    chk("R7 tx flag seen by host", hq, 8'hA5);
    for (int i = 0; i < BLEN; i++) begin
      cyc(0, RXF, 8'h00, 0, TXB + 10'(i), 8'h00);
      chk("R8 tx buffer byte", cq, pat(0, i, round));
    end
    cyc(0, TXF, 8'h00, 1, TXF, 8'h00);
    chk("R4 tx flag read during clear", hq, 8'hA5);
    cyc(0, TXF, 8'h00, 0, RXF, 8'h00);
    chk("R7 tx flag cleared", hq, 8'h00);
  endtask

  task automatic ctl_to_host(input int round);
    for (int i = 0; i < BLEN; i++) begin
      cyc(0, RXF, 8'h00, 1, RXB + 10'(i), pat(1, i, round));
      chk("R7 rx flag set before data complete", hq, 8'h00);
    end
    cyc(0, RXF, 8'h00, 1, RXF, 8'hA5);
    chk("R4 rx flag read during set", hq, 8'h00);
    cyc(0, RXF, 8'h00, 0, RXF, 8'h00);
    chk("R7 rx flag seen by host", hq, 8'hA5);
    for (int i = 0; i < BLEN; i++) begin
      cyc(0, RXB + 10'(i), 8'h00, 0, TXF, 8'h00);
      chk("R8 rx buffer byte", hq, pat(1, i, round));
    end
    cyc(1, RXF, 8'h00, 0, RXF, 8'h00);
    chk("R4 rx flag read during clear", cq, 8'hA5);
    cyc(0, TXF, 8'h00, 0, RXF, 8'h00);
    chk("R7 rx flag cleared", cq, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: flags clear after reset, both ports
    cyc(0, RXF, 8'h00, 0, TXF, 8'h00);
    chk("R1 host rx flag", hq, 8'h00);
    chk("R1 ctl tx flag", cq, 8'h00);
    cyc(0, TXF, 8'h00, 0, RXF, 8'h00);
    chk("R1 host tx flag", hq, 8'h00);
    chk("R1 ctl rx flag", cq, 8'h00);
    chk("R6 no collision idle", {7'b0, colq}, 8'h00);

    // R2 / R3: sweep of a scratch region, writes on one side, reads on the other
    for (int i = 0; i < 64; i++) begin
      cyc(1, 10'h200 + 10'(i), 8'(i * 3 + 1), 1, 10'h300 + 10'(i), 8'(255 - i));
      chk("R6 disjoint writes no collision", {7'b0, colq}, 8'h00);
    end
    for (int i = 0; i < 64; i++) begin
      cyc(0, 10'h300 + 10'(i), 8'h00, 0, 10'h200 + 10'(i), 8'h00);
      chk("R3 host reads ctl byte", hq, 8'(255 - i));
      chk("R2 ctl reads host byte", cq, 8'(i * 3 + 1));
    end
    cyc(1, 10'h3FF, 8'h7E, 0, 10'h000, 8'h00);
    cyc(0, 10'h3FF, 8'h00, 0, 10'h3FF, 8'h00);
    chk("R3 top address host", hq, 8'h7E);
    chk("R3 top address ctl", cq, 8'h7E);

    // R4: read-first on buffer bytes
    cyc(1, 10'h250, 8'h11, 0, 10'h000, 8'h00);
    cyc(0, 10'h250, 8'h00, 1, 10'h250, 8'h22);
    chk("R4 host read old across ports", hq, 8'h11);
    chk("R4 ctl read old same port", cq, 8'h11);
    cyc(0, 10'h250, 8'h00, 0, 10'h250, 8'h00);
    chk("R4 new value after write", hq, 8'h22);

    // R5: same-address clash, controller wins
    cyc(1, 10'h260, 8'h5A, 1, 10'h260, 8'hC3);
    chk("R5 collision pulse", {7'b0, colq}, 8'h01);
    cyc(0, 10'h260, 8'h00, 0, 10'h260, 8'h00);
    chk("R5 collision one clock", {7'b0, colq}, 8'h00);
    chk("R5 controller data kept", hq, 8'hC3);
    cyc(1, TXF, 8'h33, 1, TXF, 8'h44);
    chk("R5 flag clash pulse", {7'b0, colq}, 8'h01);
    cyc(0, TXF, 8'h00, 0, TXF, 8'h00);
    chk("R5 flag clash winner", hq, 8'h44);
    cyc(0, 10'h000, 8'h00, 1, TXF, 8'h00);

    // R7 / R8: full message transfers in both directions
    for (int r = 0; r < 2; r++) begin
      host_to_ctl(r);
      ctl_to_host(r);
    end
    cyc(0, TXB, 8'h00, 0, TXB + 10'(BLEN - 1), 8'h00);
    chk("R8 tx buffer untouched by rx traffic", hq, pat(0, 0, 1));
    chk("R8 tx buffer last byte", cq, pat(0, BLEN - 1, 1));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule